// File: doc/BRIEF.md
# DDR2 Auto-Refresh Interval Scheduler

This block is the refresh timer of a DDR2 memory controller. It holds a programmable refresh divisor and counts memory-clock cycles once the power-up sequence has finished. Each time the count reaches the divisor, it raises a refresh request toward the command sequencer. The request stays asserted until the sequencer acknowledges it.

The counter reloads at the moment of time-out, not when the acknowledge arrives. A refresh that is held back behind an active access therefore does not shift later refreshes. Software programs the divisor as the refresh period in clocks minus the row-cycle time (tRAS + tRP), so a deferred refresh still meets the average refresh period. For example, 200 MHz × 7.8 µs gives 1560 cycles, and with tRAS = 8 and tRP = 3 the divisor is 1549.

The divisor may change only before power-up or while the controller is idle. A write at any other time is dropped and latches a sticky status flag. A second time-out while a request is still pending latches a sticky overrun flag.

Top module: `ddr2_refresh_timer`

## Requirements
- R1: After reset, `refresh_req`, `wr_ignored` and `overrun` are 0, and the stored divisor is 0.
- R2: With a non-zero divisor D loaded, the first `refresh_req` rises D clock edges after the first edge on which `pwrup_done` is sampled high.
- R3: While `pwrup_done` stays high and the divisor stays at D, consecutive time-outs are exactly D cycles apart, whenever they are acknowledged.
- R4: Once raised, `refresh_req` stays high until an edge that samples `refresh_ack` = 1 with `access_active` = 0, and it falls after that edge.
- R5: An acknowledge sampled while `access_active` = 1 has no effect, and the request remains pending.
- R6: A time-out while the request is pending and not acknowledged on that edge sets the sticky `overrun` flag. It queues no second request, so one acknowledge clears `refresh_req`.
- R7: When a time-out and an accepted acknowledge fall on the same edge, `refresh_req` stays high as the new request and `overrun` is not set.
- R8: A `cfg_wr` pulse loads `cfg_div` when `pwrup_done` = 0 or `ctrl_idle` = 1. The new value applies to the count in progress: a time-out occurs on the first edge where the cycles elapsed since the last reload reach the value minus one.
- R9: A `cfg_wr` pulse with `pwrup_done` = 1 and `ctrl_idle` = 0 leaves the divisor unchanged and sets the sticky `wr_ignored` flag.
- R10: A divisor of 0 disables refresh generation, and no request rises.
- R11: While `pwrup_done` = 0 the counter does not advance, and no request rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Divisor write strobe |
| cfg_div | input | CNT_W | Divisor value to write |
| pwrup_done | input | 1 | DDR2 power-up sequence complete |
| ctrl_idle | input | 1 | Controller idle, divisor may change |
| access_active | input | 1 | A memory access is in progress |
| refresh_ack | input | 1 | Sequencer accepts the pending refresh |
| refresh_req | output | 1 | Refresh request, held until acknowledged |
| wr_ignored | output | 1 | Sticky: a divisor write was dropped |
| overrun | output | 1 | Sticky: time-out while a request was pending |

## Verification
A time-out and an acknowledge can land on the same edge, and the outcome decides whether a refresh is lost or wrongly flagged as an overrun. The bench provokes this by counting cycles from a known request edge and raising the acknowledge on the cycle just before the next expiry. It then expects the request to stay high with no overrun, and expects a single later acknowledge to clear it. A divisor write can also coincide with a time-out or a reload. The random phase covers that case, with small divisors and frequent writes, against a bench model in which the old divisor governs the expiring edge.

// File: rtl/ddr2_refresh_timer.sv
`timescale 1ns/1ps
module ddr2_refresh_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [CNT_W-1:0] cfg_div,
  input  logic             pwrup_done,
  input  logic             ctrl_idle,
  input  logic             access_active,
  input  logic             refresh_ack,
  output logic             refresh_req,
  output logic             wr_ignored,
  output logic             overrun
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] div_q;
  logic [CNT_W-1:0] elapsed;

  wire running = pwrup_done && (div_q != '0);
  wire expire  = running && (elapsed >= div_q - ONE);
  wire wr_ok   = !pwrup_done || ctrl_idle;
  wire ack_ok  = refresh_ack && !access_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q      <= '0;
      wr_ignored <= 1'b0;
    end else if (cfg_wr) begin
      if (wr_ok) div_q <= cfg_div;
      else       wr_ignored <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 elapsed <= '0;
    else if (!running || expire) elapsed <= '0;
    else                        elapsed <= elapsed + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      refresh_req <= 1'b0;
      overrun     <= 1'b0;
    end else if (expire) begin
      refresh_req <= 1'b1;
      if (refresh_req && !ack_ok) overrun <= 1'b1;
    end else if (ack_ok) begin
      refresh_req <= 1'b0;
    end
  end

  p_hold_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_req && !ack_ok |=> refresh_req);

  p_ack_blocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_req && refresh_ack && access_active |=> refresh_req);

  p_no_req_before_pwrup_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !pwrup_done && !refresh_req |=> !refresh_req);

  p_disabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
    div_q == '0 && !refresh_req |=> !refresh_req);

  p_ignore_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && pwrup_done && !ctrl_idle |=> $stable(div_q) && wr_ignored);

  p_sticky_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  p_sticky_ign_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ignored |=> wr_ignored);

  p_coincide_r7: assert property (@(posedge clk) disable iff (!rst_n)
    expire && ack_ok && !overrun |=> refresh_req && !overrun);

endmodule

// File: tb/sim_ddr2_refresh_timer.sv
`timescale 1ns/1ps
module sim_ddr2_refresh_timer;

  localparam int W = 16;
  localparam int D = 1549;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [W-1:0] cfg_div = '0;
  logic pwrup_done = 1'b0, ctrl_idle = 1'b0, access_active = 1'b0, refresh_ack = 1'b0;
  logic refresh_req, wr_ignored, overrun;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ddr2_refresh_timer #(.CNT_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_div(cfg_div),
    .pwrup_done(pwrup_done), .ctrl_idle(ctrl_idle), .access_active(access_active),
    .refresh_ack(refresh_ack), .refresh_req(refresh_req),
    .wr_ignored(wr_ignored), .overrun(overrun)
  );

  logic [W-1:0] m_div, m_el;
  logic m_req, m_ign, m_ovf;

  function automatic bit times_out(logic pw, logic [W-1:0] dv, logic [W-1:0] el);
    return pw && (dv != 0) && (32'(el) + 1 >= 32'(dv));
  endfunction

  function automatic bit write_allowed(logic pw, logic idle);
    return !pw || idle;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_div <= '0; m_el <= '0; m_req <= 1'b0; m_ign <= 1'b0; m_ovf <= 1'b0;
    end else begin
      automatic bit to = times_out(pwrup_done, m_div, m_el);
      automatic bit ak = refresh_ack && !access_active;
      if (cfg_wr) begin
        if (write_allowed(pwrup_done, ctrl_idle)) m_div <= cfg_div;
        else m_ign <= 1'b1;
      end
      if (!(pwrup_done && m_div != 0) || to) m_el <= '0;
      else m_el <= m_el + 1'b1;
      if (to) begin
        if (m_req && !ak) m_ovf <= 1'b1;
        m_req <= 1'b1;
      end else if (ak) m_req <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      chk(refresh_req == m_req, "R3 model refresh_req", int'(refresh_req), int'(m_req));
      chk(wr_ignored == m_ign, "R9 model wr_ignored", int'(wr_ignored), int'(m_ign));
      chk(overrun == m_ovf, "R6 model overrun", int'(overrun), int'(m_ovf));
    end
  end

  task automatic nclk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_req(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!refresh_req && n < 5000);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int n;
    bool_dummy: begin end
    nclk(3);
    chk(refresh_req == 0 && wr_ignored == 0 && overrun == 0, "R1 reset outputs",
        int'({refresh_req, wr_ignored, overrun}), 0);
    rst_n = 1'b1;
    nclk(1);
    cfg_wr = 1'b1; cfg_div = W'(D);
    nclk(1);
    cfg_wr = 1'b0;
    begin
      bit seen = 1'b0;
      for (int i = 0; i < 50; i++) begin
        @(negedge clk);
        if (refresh_req) seen = 1'b1;
      end
      chk(!seen, "R11 no request before power-up", int'(seen), 0);
    end
    pwrup_done = 1'b1; ctrl_idle = 1'b1;
    wait_req(n);
    chk(n == D, "R2 first request delay", n, D);
    access_active = 1'b1; refresh_ack = 1'b1;
    nclk(100);
    chk(refresh_req == 1, "R5 ack during access ignored", int'(refresh_req), 1);
    access_active = 1'b0;
    nclk(1);
    chk(refresh_req == 0, "R4 accepted ack clears request", int'(refresh_req), 0);
    refresh_ack = 1'b0;
    wait_req(n);
    chk(101 + n == D, "R3 spacing with deferred ack", 101 + n, D);
    nclk(D - 1);
    refresh_ack = 1'b1;
    nclk(1);
    chk(refresh_req == 1 && overrun == 0, "R7 ack coincides with time-out",
        int'({refresh_req, overrun}), 2);
    nclk(1);
    refresh_ack = 1'b0;
    chk(refresh_req == 0, "R7 single ack then clears", int'(refresh_req), 0);
    ctrl_idle = 1'b0; cfg_wr = 1'b1; cfg_div = W'(100);
    nclk(1);
    cfg_wr = 1'b0;
    chk(wr_ignored == 1, "R9 write while busy flagged", int'(wr_ignored), 1);
    wait_req(n);
    chk(2 + n == D, "R9 divisor unchanged after ignored write", 2 + n, D);
    ctrl_idle = 1'b1;
    nclk(D - 1);
    chk(overrun == 0, "R6 no overrun before second time-out", int'(overrun), 0);
    nclk(1);
    chk(overrun == 1 && refresh_req == 1, "R6 overrun on pending time-out",
        int'({overrun, refresh_req}), 3);
    refresh_ack = 1'b1;
    nclk(1);
    refresh_ack = 1'b0;
    chk(refresh_req == 0, "R6 one ack clears, nothing queued", int'(refresh_req), 0);
    cfg_wr = 1'b1; cfg_div = '0;
    nclk(1);
    cfg_wr = 1'b0;
    begin
      bit seen = 1'b0;
      for (int i = 0; i < 3000; i++) begin
        @(negedge clk);
        if (refresh_req) seen = 1'b1;
      end
      chk(!seen, "R10 zero divisor disables refresh", int'(seen), 0);
    end
    cfg_wr = 1'b1; cfg_div = W'(7);
    nclk(1);
    cfg_wr = 1'b0;
    wait_req(n);
    chk(n == 7, "R8 idle write applies to running count", n, 7);

    rst_n = 1'b0;
    nclk(2);
    rst_n = 1'b1;
    void'($urandom(32'd2024));
    for (int i = 0; i < 30000; i++) begin
      @(negedge clk);
      cfg_wr        = ($urandom % 16) == 0;
      cfg_div       = W'($urandom % 24);
      if (($urandom % 200) == 0) pwrup_done = ~pwrup_done;
      ctrl_idle     = ($urandom % 3) != 0;
      access_active = ($urandom % 4) == 0;
      refresh_ack   = ($urandom % 3) == 0;
      if (i == 0) begin pwrup_done = 1'b0; cfg_wr = 1'b1; cfg_div = W'(5); end
      if (i == 10) pwrup_done = 1'b1;
    end
    nclk(2);
    finish_run();
  end

endmodule